// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

A watchdog timer on a plain word-addressed register bus: an address, write data and a write strobe, with read data returned combinationally for the addressed word. Software sets a 12-bit coarse timeout and picks one of four clock dividers. It then enables the block and must keep writing a fixed restart word before a down-counter runs out. When the counter runs out, the block raises a status flag. It can also drive a one-shot reset pulse of programmable length, a sticky interrupt level, or both.

Stray writes cannot reconfigure the block. The mode word and the counter-control word each carry a 12-bit key field, and a write whose key field is wrong changes nothing. Only one full 32-bit value restarts the counter. The counter reloads to the coarse field followed by a block of all-one low bits. The width of that block is a parameter: 12 in the product build, narrower for short simulations.

Top module: `keyed_wdog`

## Requirements
- R1: After reset all registers read 0, the counter is stopped, and both `wdt_rst_o` and `wdt_irq_o` are low.
- R2: A write to byte offset 0x0 (mode word) updates it only when bits [23:12] equal 0xABC; otherwise the stored mode is unchanged. The mode word fields are: bit 0 enable, bit 1 reset-output enable, bit 2 interrupt enable, bits [6:4] pulse-length code.
- R3: A write to offset 0x4 (counter-control word) updates it only when bits [25:14] equal 0x248, which is the word pattern 0x0092_0000. The fields are bits [13:2] for the coarse reload value and bits [1:0] for the divider code.
- R4: Reading offset 0x0 or 0x4 returns the stored fields in their write positions with all other bits 0. Offset 0x8 reads 0.
- R5: While enabled, the counter starts at {coarse, LOW_W ones} and decrements once per divided tick. It expires exactly reload×divisor clock edges after the enabling write or the last restart.
- R6: Divider code 0, 1, 2 and 3 divide the clock by 8, 64, 512 and 4096.
- R7: Writing exactly 0x0000_1999 to offset 0x8 reloads the counter and restarts the divider. Any other value there does not move the expiry time.
- R8: On expiry, offset 0xC bit 0 reads 1. It reads 0 again after a restart or after a disable.
- R9: With reset output enabled, expiry gives one `wdt_rst_o` pulse of 2^(code+1) cycles, so code 3 gives 16 cycles. No further pulse follows while the block stays expired.
- R10: With interrupt enabled, `wdt_irq_o` rises at expiry and stays high until a restart or a disable.
- R11: A mode write that clears the enable bit stops the counter. The status bit and both outputs drop at that write's clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte offset; bits [3:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wdt_rst_o | output | 1 | Timed reset pulse on expiry |
| wdt_irq_o | output | 1 | Interrupt level on expiry |

## Verification
Most internal faults in this block show up as a shift in the time of expiry. A divider that ends its period one count early, or a reload missing its low ones, moves the status bit's rising edge by whole ticks. The bench therefore samples that bit on the cycle just before and just after the predicted edge. A key decoder that is too permissive shows on the next read of the word it protects. A pulse counter with a bad length shows within 2^(code+1) cycles after expiry, and a re-armed pulse shows some hundreds of cycles later. Clearing logic that does not respond shows on the first sample after the restart or disable write.

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
  parameter int          CRV_W    = 12,
  parameter int          LOW_W    = 12,
  parameter int          LEN_W    = 3,
  parameter logic [11:0] MODE_KEY = 12'hABC,
  parameter logic [11:0] CTRL_KEY = 12'h248,
  parameter logic [31:0] KICK_KEY = 32'h0000_1999
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_we,
  output logic [31:0] bus_rdata,
  output logic        wdt_rst_o,
  output logic        wdt_irq_o
);

  localparam int CNT_W   = CRV_W + LOW_W;
  localparam int PSC_W   = 12;
  localparam int PULSE_W = (1 << LEN_W) + 1;
  localparam int KLO     = CRV_W + 2;

  logic             en_q, rst_en_q, irq_en_q;
  logic [LEN_W-1:0] len_q;
  logic [CRV_W-1:0] crv_q;
  logic [1:0]       psel_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PSC_W-1:0] psc_q, div_m1;
  logic [PULSE_W-1:0] pulse_q, pulse_len;
  logic             expired_q, irq_q;

  wire wr_mode = bus_we && bus_addr[3:2] == 2'd0 && bus_wdata[23:12] == MODE_KEY;
  wire wr_ctrl = bus_we && bus_addr[3:2] == 2'd1 && bus_wdata[KLO+11:KLO] == CTRL_KEY;
  wire kick    = bus_we && bus_addr[3:2] == 2'd2 && bus_wdata == KICK_KEY;
  wire en_nxt  = wr_mode ? bus_wdata[0] : en_q;
  wire tick    = psc_q >= div_m1;
  wire [CNT_W-1:0] reload = {crv_q, {LOW_W{1'b1}}};

  always_comb begin
    case (psel_q)
      2'd0:    div_m1 = PSC_W'(7);
      2'd1:    div_m1 = PSC_W'(63);
      2'd2:    div_m1 = PSC_W'(511);
      default: div_m1 = PSC_W'(4095);
    endcase
  end

  assign pulse_len = PULSE_W'(2) << len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; rst_en_q <= 1'b0; irq_en_q <= 1'b0; len_q <= '0;
      crv_q <= '0; psel_q <= '0;
    end else begin
      if (wr_mode) begin
        en_q     <= bus_wdata[0];
        rst_en_q <= bus_wdata[1];
        irq_en_q <= bus_wdata[2];
        len_q    <= bus_wdata[4 +: LEN_W];
      end
      if (wr_ctrl) begin
        crv_q  <= bus_wdata[KLO-1:2];
        psel_q <= bus_wdata[1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; psc_q <= '0; pulse_q <= '0; expired_q <= 1'b0; irq_q <= 1'b0;
    end else if (!en_nxt) begin
      cnt_q <= reload; psc_q <= '0; pulse_q <= '0; expired_q <= 1'b0; irq_q <= 1'b0;
    end else if (!en_q || kick) begin
      cnt_q <= reload; psc_q <= '0; expired_q <= 1'b0; irq_q <= 1'b0;
      if (pulse_q != '0) pulse_q <= pulse_q - 1'b1;
    end else begin
      psc_q <= tick ? '0 : psc_q + 1'b1;
      if (pulse_q != '0) pulse_q <= pulse_q - 1'b1;
      if (tick && cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          expired_q <= 1'b1;
          irq_q     <= irq_en_q;
          if (rst_en_q) pulse_q <= pulse_len;
        end
      end
    end
  end

  always_comb begin
    case (bus_addr[3:2])
      2'd0:    bus_rdata = 32'({len_q, 1'b0, irq_en_q, rst_en_q, en_q});
      2'd1:    bus_rdata = 32'({crv_q, psel_q});
      2'd2:    bus_rdata = '0;
      default: bus_rdata = {31'b0, expired_q};
    endcase
  end

  assign wdt_rst_o = pulse_q != '0;
  assign wdt_irq_o = irq_q;

  p_mode_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[3:2] == 2'd0 && bus_wdata[23:12] != MODE_KEY)
      |=> $stable({en_q, rst_en_q, irq_en_q, len_q}));

  p_ctrl_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[3:2] == 2'd1 && bus_wdata[KLO+11:KLO] != CTRL_KEY)
      |=> $stable({crv_q, psel_q}));

  p_cnt_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q) && !$past(kick)) |-> cnt_q <= $past(cnt_q));

  p_pulse_on_expiry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q != '0 && $past(pulse_q) == '0) |-> $rose(expired_q));

  p_irq_has_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> expired_q);

  p_quiet_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!irq_q && pulse_q == '0 && !expired_q));

endmodule

// File: tb/keyed_wdog_tb.sv
module keyed_wdog_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = 4'hC;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        wdt_rst_o, wdt_irq_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int wr_at  = 0;

  localparam logic [31:0] MK = 32'h00AB_C000;
  localparam logic [31:0] CK = 32'h0092_0000;

  keyed_wdog #(.LOW_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .wdt_rst_o(wdt_rst_o), .wdt_irq_o(wdt_irq_o)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    wr_at = cyc;
    bus_we = 1'b0; bus_addr = 4'hC;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata; bus_addr = 4'hC;
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(4'h0, d); chk("R1 mode", d, 0);
    rd(4'h4, d); chk("R1 ctrl", d, 0);
    rd(4'hC, d); chk("R1 status", d, 0);
    chk("R1 rst", wdt_rst_o, 0);
    chk("R1 irq", wdt_irq_o, 0);
  endtask

  task automatic t_keys;
    logic [31:0] d;
    wr(4'h0, 32'h00AB_D036); rd(4'h0, d); chk("R2 bad key", d, 0);
    wr(4'h0, MK | 32'hFF00_0036); rd(4'h0, d); chk("R2/R4 good key", d, 32'h36);
    wr(4'h0, 32'h00AB_B001); rd(4'h0, d); chk("R2 bad key kept", d, 32'h36);
    wr(4'h0, MK);
    wr(4'h4, CK | 32'h4); rd(4'h4, d); chk("R3/R4 ctrl", d, 32'h4);
    wr(4'h4, 32'h0093_0007); rd(4'h4, d); chk("R3 bad key kept", d, 32'h4);
    wr(4'h8, 32'h0000_1999); rd(4'h8, d); chk("R4 kick reads 0", d, 0);
  endtask

  task automatic t_timeout_irq;
    int p, q;
    logic [31:0] d;
    wr(4'h0, MK | 32'h5); p = wr_at;
    wait_to(p + 247); rd(4'hC, d); chk("R5 before expiry", d, 0);
    chk("R10 irq low", wdt_irq_o, 0);
    wait_to(p + 248); rd(4'hC, d); chk("R5/R8 expiry div8", d, 1);
    chk("R10 irq rise", wdt_irq_o, 1);
    wait_to(p + 268);
    chk("R10 irq held", wdt_irq_o, 1);
    chk("R9 no pulse when off", wdt_rst_o, 0);
    wr(4'h8, 32'h0000_1998);
    chk("R7 bad kick irq", wdt_irq_o, 1);
    wr(4'h8, 32'h0000_1999); q = wr_at;
    rd(4'hC, d); chk("R8 clear on kick", d, 0);
    chk("R10 irq clear", wdt_irq_o, 0);
    wait_to(q + 100); wr(4'h8, 32'h1999_0000);
    wait_to(q + 247); rd(4'hC, d); chk("R7 reload timing early", d, 0);
    wait_to(q + 248); rd(4'hC, d); chk("R7 reload timing", d, 1);
    wr(4'h0, MK);
    rd(4'hC, d); chk("R11 status off", d, 0);
    chk("R11 irq off", wdt_irq_o, 0);
    wait_to(wr_at + 400); rd(4'hC, d); chk("R11 stopped", d, 0);
  endtask

  task automatic t_div(input logic [1:0] code, input int div);
    int p;
    logic [31:0] d;
    wr(4'h4, CK | 32'(code));
    wr(4'h0, MK | 32'h1); p = wr_at;
    wait_to(p + 15 * div - 1); rd(4'hC, d); chk("R6 before expiry", d, 0);
    wait_to(p + 15 * div); rd(4'hC, d); chk("R6 expiry", d, 1);
    wr(4'h0, MK);
  endtask

  task automatic t_pulse(input logic [2:0] code);
    int p, len;
    len = 2 << code;
    wr(4'h4, CK);
    wr(4'h0, MK | 32'h3 | (32'(code) << 4)); p = wr_at;
    wait_to(p + 119); chk("R9 low before", wdt_rst_o, 0);
    wait_to(p + 120); chk("R9 pulse start", wdt_rst_o, 1);
    wait_to(p + 119 + len); chk("R9 pulse last", wdt_rst_o, 1);
    chk("R9 no irq", wdt_irq_o, 0);
    wait_to(p + 120 + len); chk("R9 pulse end", wdt_rst_o, 0);
    wait_to(p + 500); chk("R9 single pulse", wdt_rst_o, 0);
    wr(4'h0, MK);
  endtask

  task automatic t_both_disable;
    int p;
    wr(4'h4, CK);
    wr(4'h0, MK | 32'h37); p = wr_at;
    wait_to(p + 120);
    chk("R9 both rst", wdt_rst_o, 1);
    chk("R10 both irq", wdt_irq_o, 1);
    wait_to(p + 124);
    wr(4'h0, MK | 32'h36);
    chk("R11 rst drop", wdt_rst_o, 0);
    chk("R11 irq drop", wdt_irq_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_keys;
    wr(4'h4, CK | 32'h4);
    t_timeout_irq;
    t_div(2'd1, 64);
    t_div(2'd2, 512);
    t_div(2'd0, 8);
    t_pulse(3'd3);
    t_pulse(3'd1);
    t_both_disable;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule